// File: doc/BRIEF.md
# Memory Fault Classifier

This block sorts a fault event into one class when the fault strobe is sampled. The strobe comes with a fault-count field, a flag that says whether the emulator task was the source, an indication that the error status shows trouble other than a map fault, and two stack-status bits. The count field is decoded by its value. All ones means there is no memory-system fault, so the stack bits decide the class. All zeros means exactly one memory fault. Any other value means several faults. A single fault is then split by its source and by the kind of trouble.

The class is stored as a 3-bit code and as a one-hot vector. It stays in place until an acknowledge clears it. There are two recoverable classes: an emulator map fault and a stack error. For either one the block gives a one-cycle pulse telling the emulator to take over. It also captures the emulator's program counter, which arrives complemented and is stored inverted back, and the data word being stored. For fatal classes a halt code names the reason.

Top module: `fault_classifier`

## Requirements
- R1: After reset, cls_code is 0 (none), cls_onehot is all zeros, emu_pass is 0 and halt_code is 0.
- R2: A strobe with flt_cnt all ones and at least one stack bit set gives code 2 (stack error). stk_err[1] is overflow and stk_err[0] is underflow.
- R3: A strobe with flt_cnt all ones and both stack bits clear gives code 6 (unknown).
- R4: A strobe with flt_cnt neither all ones nor all zeros gives code 3 (many faults), whatever the other inputs are.
- R5: A strobe with flt_cnt all zeros and emu_src low gives code 4 (non-emulator fault).
- R6: A strobe with flt_cnt all zeros, emu_src high and map_bad high gives code 5 (non-map fault).
- R7: A strobe with flt_cnt all zeros, emu_src high and map_bad low gives code 1 (emulator map fault).
- R8: emu_pass is high for exactly the one cycle after an accepted strobe whose class is 1 or 2. It is low otherwise.
- R9: On an accepted recoverable strobe, cap_pc becomes the bitwise inverse of pc_n and cap_data becomes store_data. A fatal class leaves both unchanged.
- R10: An accepted class holds until flt_ack. A strobe that arrives while a class is held, with no acknowledge in the same cycle, is ignored. An acknowledge alone clears the code to 0. An acknowledge together with a strobe loads the new class.
- R11: halt_code equals cls_code when cls_code is 3 or above, and is 0 otherwise.
- R12: cls_onehot bit (cls_code-1) is set for codes 1 to 6, and no other bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_stb | input | 1 | Fault event strobe |
| flt_ack | input | 1 | Clears the held class |
| flt_cnt | input | CNT_W | Fault-count field |
| emu_src | input | 1 | Fault came from the emulator task |
| map_bad | input | 1 | Error status shows trouble other than a map fault |
| stk_err | input | 2 | Bit 1 overflow, bit 0 underflow |
| pc_n | input | PC_W | Complemented emulator program counter |
| store_data | input | DATA_W | Data word being stored |
| cls_code | output | 3 | Held class code |
| cls_onehot | output | 6 | One-hot form of the class code |
| emu_pass | output | 1 | Pass-to-emulator pulse |
| halt_code | output | 3 | Fatal reason, 0 when none |
| cap_pc | output | PC_W | Captured, inverted program counter |
| cap_data | output | DATA_W | Captured store data |

## Verification
The assertions assume that flt_stb and flt_ack are known, 0 or 1, on every clock after reset. They also assume that pc_n is stable in the cycle when a strobe is sampled, because the capture check compares against the value sampled with the strobe. The bench drives every input on the falling edge, holds each strobe and acknowledge for exactly one cycle, and returns both to zero between scenarios. It also sends a strobe while a class is held and another together with an acknowledge, to exercise the hold and override rules.

// File: rtl/fltc_pkg.sv
package fltc_pkg;
   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_MAPF    = 3'd1,
      FC_STACK   = 3'd2,
      FC_MANY    = 3'd3,
      FC_NOTEMU  = 3'd4,
      FC_NOTMAP  = 3'd5,
      FC_UNKNOWN = 3'd6
   } fclass_t;

   localparam int FC_NUM = 6;
   localparam logic [2:0] FC_FIRST_FATAL = 3'd3;
endpackage

// File: rtl/fltc_decode.sv
module fltc_decode #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             emu_src,
   input  logic             map_bad,
   input  logic [1:0]       stk,
   output fltc_pkg::fclass_t cls,
   output logic             recov
);
   import fltc_pkg::*;

   logic no_mem_fault;
   logic one_fault;

   assign no_mem_fault = &cnt;
   assign one_fault    = ~|cnt;

   always_comb begin
      if (no_mem_fault) begin
         cls = (stk != 2'b00) ? FC_STACK : FC_UNKNOWN;
      end else if (!one_fault) begin
         cls = FC_MANY;
      end else if (!emu_src) begin
         cls = FC_NOTEMU;
      end else if (map_bad) begin
         cls = FC_NOTMAP;
      end else begin
         cls = FC_MAPF;
      end
   end

   assign recov = (cls == FC_MAPF) || (cls == FC_STACK);
endmodule

// File: rtl/fltc_state.sv
module fltc_state (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              ack,
   input  fltc_pkg::fclass_t cls_in,
   input  logic              recov_in,
   output fltc_pkg::fclass_t code,
   output logic              accept,
   output logic              pass
);
   import fltc_pkg::*;

   assign accept = stb && ((code == FC_NONE) || ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= FC_NONE;
         pass <= 1'b0;
      end else begin
         pass <= accept && recov_in;
         if (accept) begin
            code <= cls_in;
         end else if (ack) begin
            code <= FC_NONE;
         end
      end
   end
endmodule

// File: rtl/fltc_capture.sv
module fltc_capture #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PC_W-1:0]   pc_n,
   input  logic [DATA_W-1:0] data,
   output logic [PC_W-1:0]   pc_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         data_q <= '0;
      end else if (load) begin
         pc_q   <= ~pc_n;
         data_q <= data;
      end
   end
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier #(
   parameter int CNT_W  = 2,
   parameter int PC_W   = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_stb,
   input  logic              flt_ack,
   input  logic [CNT_W-1:0]  flt_cnt,
   input  logic              emu_src,
   input  logic              map_bad,
   input  logic [1:0]        stk_err,
   input  logic [PC_W-1:0]   pc_n,
   input  logic [DATA_W-1:0] store_data,
   output logic [2:0]        cls_code,
   output logic [5:0]        cls_onehot,
   output logic              emu_pass,
   output logic [2:0]        halt_code,
   output logic [PC_W-1:0]   cap_pc,
   output logic [DATA_W-1:0] cap_data
);
   import fltc_pkg::*;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("PC_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   fclass_t dec_cls;
   fclass_t held;
   logic    dec_recov;
   logic    accept;

   fltc_decode #(.CNT_W(CNT_W)) u_decode (
      .cnt     (flt_cnt),
      .emu_src (emu_src),
      .map_bad (map_bad),
      .stk     (stk_err),
      .cls     (dec_cls),
      .recov   (dec_recov)
   );

   fltc_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (flt_stb),
      .ack      (flt_ack),
      .cls_in   (dec_cls),
      .recov_in (dec_recov),
      .code     (held),
      .accept   (accept),
      .pass     (emu_pass)
   );

   fltc_capture #(.PC_W(PC_W), .DATA_W(DATA_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept && dec_recov),
      .pc_n   (pc_n),
      .data   (store_data),
      .pc_q   (cap_pc),
      .data_q (cap_data)
   );

   assign cls_code  = held;
   assign halt_code = (held >= FC_FIRST_FATAL) ? held : 3'd0;

   for (genvar i = 0; i < FC_NUM; i++) begin : g_onehot
      assign cls_onehot[i] = (held == 3'(i + 1));
   end
endmodule

// File: rtl/fltc_checker.sv
module fltc_checker #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flt_stb,
   input logic            flt_ack,
   input logic [PC_W-1:0] pc_n,
   input logic [2:0]      cls_code,
   input logic [5:0]      cls_onehot,
   input logic            emu_pass,
   input logic [2:0]      halt_code,
   input logic [PC_W-1:0] cap_pc
);
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_code != 3'd0 && !flt_ack) |=> $stable(cls_code)); // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_ack && !flt_stb) |=> (cls_code == 3'd0)); // R10
   AST_PASS_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      emu_pass |-> $past(flt_stb)); // R8
   AST_PASS_RECOVERABLE: assert property (@(posedge clk) disable iff (!rst_n)
      emu_pass |-> (cls_code == 3'd1 || cls_code == 3'd2)); // R8
   AST_PC_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      emu_pass |-> (cap_pc == ~$past(pc_n))); // R9
   AST_HALT_ONLY_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_code != 3'd0) |-> (cls_code >= 3'd3)); // R11
   AST_ONEHOT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cls_onehot)); // R12
endmodule

bind fault_classifier fltc_checker #(.PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flt_stb    (flt_stb),
   .flt_ack    (flt_ack),
   .pc_n       (pc_n),
   .cls_code   (cls_code),
   .cls_onehot (cls_onehot),
   .emu_pass   (emu_pass),
   .halt_code  (halt_code),
   .cap_pc     (cap_pc)
);

// File: tb/fault_classifier_tb.sv
module fault_classifier_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 2;
   localparam int PC_W   = 16;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flt_stb = 1'b0;
   logic              flt_ack = 1'b0;
   logic [CNT_W-1:0]  flt_cnt = '0;
   logic              emu_src = 1'b0;
   logic              map_bad = 1'b0;
   logic [1:0]        stk_err = 2'b00;
   logic [PC_W-1:0]   pc_n = '0;
   logic [DATA_W-1:0] store_data = '0;
   logic [2:0]        cls_code;
   logic [5:0]        cls_onehot;
   logic              emu_pass;
   logic [2:0]        halt_code;
   logic [PC_W-1:0]   cap_pc;
   logic [DATA_W-1:0] cap_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [PC_W-1:0]   exp_pc = '0;
   logic [DATA_W-1:0] exp_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_classifier #(.CNT_W(CNT_W), .PC_W(PC_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_ack(flt_ack),
      .flt_cnt(flt_cnt), .emu_src(emu_src), .map_bad(map_bad),
      .stk_err(stk_err), .pc_n(pc_n), .store_data(store_data),
      .cls_code(cls_code), .cls_onehot(cls_onehot), .emu_pass(emu_pass),
      .halt_code(halt_code), .cap_pc(cap_pc), .cap_data(cap_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // checks the whole view of a held class
   task automatic chk_class(input string req, input int code, input int pass);
      chk(req, int'(cls_code), code);
      chk({req, " onehot R12"}, int'(cls_onehot), (code == 0) ? 0 : (1 << (code - 1)));
      chk({req, " halt R11"}, int'(halt_code), (code >= 3) ? code : 0);
      chk({req, " pass R8"}, int'(emu_pass), pass);
      chk({req, " pc R9"}, int'(cap_pc), int'(exp_pc));
      chk({req, " data R9"}, int'(cap_data), int'(exp_data));
   endtask

   task automatic fire(input logic [CNT_W-1:0] c, input logic e, input logic m,
                       input logic [1:0] s, input logic [PC_W-1:0] p,
                       input logic [DATA_W-1:0] d, input logic with_ack);
      @(negedge clk);
      flt_cnt = c; emu_src = e; map_bad = m; stk_err = s;
      pc_n = p; store_data = d; flt_stb = 1'b1; flt_ack = with_ack;
      @(negedge clk);
      flt_stb = 1'b0; flt_ack = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      flt_ack = 1'b1;
      @(negedge clk);
      flt_ack = 1'b0;
      chk("R10 ack clears", int'(cls_code), 0);
   endtask

   task automatic t_reset();
      chk_class("R1 reset", 0, 0);
   endtask

   task automatic t_mapfault();
      fire(2'b00, 1'b1, 1'b0, 2'b00, 16'h1234, 16'hBEEF, 1'b0);
      exp_pc = 16'hEDCB; exp_data = 16'hBEEF;
      chk_class("R7 map fault", 1, 1);
      @(negedge clk);
      chk("R8 pulse one cycle", int'(emu_pass), 0);
      do_ack();
   endtask

   task automatic t_stack();
      fire(2'b11, 1'b0, 1'b1, 2'b10, 16'h00FF, 16'h0A0A, 1'b0);
      exp_pc = 16'hFF00; exp_data = 16'h0A0A;
      chk_class("R2 overflow", 2, 1);
      do_ack();
      fire(2'b11, 1'b1, 1'b0, 2'b01, 16'hF0F0, 16'h5555, 1'b0);
      exp_pc = 16'h0F0F; exp_data = 16'h5555;
      chk_class("R2 underflow", 2, 1);
      do_ack();
   endtask

   task automatic t_unknown();
      fire(2'b11, 1'b1, 1'b0, 2'b00, 16'h1111, 16'h2222, 1'b0);
      chk_class("R3 unknown", 6, 0);
      do_ack();
   endtask

   task automatic t_many();
      fire(2'b01, 1'b1, 1'b0, 2'b11, 16'h3333, 16'h4444, 1'b0);
      chk_class("R4 many cnt=1", 3, 0);
      do_ack();
      fire(2'b10, 1'b0, 1'b1, 2'b00, 16'h3333, 16'h4444, 1'b0);
      chk_class("R4 many cnt=2", 3, 0);
      do_ack();
   endtask

   task automatic t_single_fatal();
      fire(2'b00, 1'b0, 1'b0, 2'b11, 16'h6666, 16'h7777, 1'b0);
      chk_class("R5 non-emulator", 4, 0);
      do_ack();
      fire(2'b00, 1'b1, 1'b1, 2'b00, 16'h8888, 16'h9999, 1'b0);
      chk_class("R6 non-map", 5, 0);
      do_ack();
   endtask

   task automatic t_hold();
      fire(2'b00, 1'b1, 1'b0, 2'b00, 16'hA5A5, 16'hC3C3, 1'b0);
      exp_pc = 16'h5A5A; exp_data = 16'hC3C3;
      chk_class("R10 first class", 1, 1);
      fire(2'b11, 1'b1, 1'b0, 2'b10, 16'h0000, 16'hFFFF, 1'b0);
      chk_class("R10 strobe ignored while held", 1, 0);
      repeat (3) @(negedge clk);
      chk_class("R10 still held", 1, 0);
      fire(2'b00, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0000, 1'b1);
      chk_class("R10 ack with strobe loads", 4, 0);
      do_ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mapfault();
      t_stack();
      t_unknown();
      t_many();
      t_single_fatal();
      t_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule